// File: doc/BRIEF.md
# Four-Dimensional Transfer Address Generator

This block takes one transfer request, described by a flags word, up to four loop counts, a 64-bit base address and three signed 32-bit strides. It walks the nested loops and issues one row request per innermost iteration. Each row request carries an address and a byte count, and it is handed over through a valid/ready handshake. The innermost count is the byte length of every row. The next count is the fastest-moving outer index, and the fourth count is the slowest. Row requests go to a data mover that sits downstream.

Two trigger channels can meter progress. Each channel picks one of three trigger lines, or none, and a trigger type that decides how much of the walk one pulse releases. The block pulses an event output at a boundary chosen by an event-size code. When the request ends it returns a 32-bit response word with a one-cycle done strobe. Requests that cannot be executed are rejected with an encoded status and issue no rows.

Top module: `trw_addr_gen`

## Requirements
- R1: Row address = base + i1·stride1 + i2·stride2 + i3·stride3, computed modulo 2^64 with the strides sign-extended. Each row's length equals the innermost count.
- R2: The record type is in flags[3:0]. Type 0 walks only the innermost count, type 1 adds count1 and stride1, type 2 adds count2 and stride2, and type 3 adds count3 and stride3. Counts beyond the type are ignored, and an outer count of zero behaves as one. i1 moves fastest and i3 slowest.
- R3: While rowValid is high and rowReady is low, rowValid stays high and rowAddr and rowLen do not change.
- R4: One cycle after the last row is accepted, respDone is high for exactly one cycle. respWord then holds the status type in [3:0], status info in [7:4], the command id from flags[23:16] in [23:16], and zero elsewhere. A finished request has status type 0.
- R5: A supported request whose innermost count is zero issues no rows. It completes one cycle after submission with status type 3 and info 0.
- R6: Record types 4 to 15 issue no rows and complete one cycle after submission with status type 4 and info 0. This check takes priority over R5.
- R7: Trigger select fields are flags[9:8] for channel 0 and flags[13:12] for channel 1. The encoding is 0 = none, 1 = trig[0], 2 = trig[1], 3 = trig[2]. A channel with select 0 never blocks. Rows are offered only while every selected channel holds an open quota.
- R8: Trigger type fields are flags[11:10] and flags[15:14]. One pulse releases one row for type 0, one full i1 loop for type 1, one full i1·i2 block for type 2, and the rest of the request for type 3.
- R9: A pulse that arrives while its channel's quota is still open is kept as one pending credit. The credit reopens the quota when the quota ends. Further pulses in that window are lost.
- R10: The event-size code is flags[7:6]. For code c from 1 to 3 with c ≤ type, eventPulse fires one cycle after each accepted row that completes loops 1 to c−1 (code 1 fires on every row). Otherwise, including code 0, it fires once, one cycle after the last row.
- R11: flags[26] = 1 suppresses every event of the request.
- R12: start is ignored while a request is running. Trigger pulses are ignored while idle and in the cycle of submission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Submit request on the inputs below |
| flags | input | 32 | Request flags word |
| cnt0 | input | 16 | Innermost count (bytes per row) |
| cnt1 | input | 16 | Loop 1 count |
| cnt2 | input | 16 | Loop 2 count |
| cnt3 | input | 16 | Loop 3 count |
| baseAddr | input | 64 | Base address |
| stride1 | input | 32 | Signed loop 1 stride |
| stride2 | input | 32 | Signed loop 2 stride |
| stride3 | input | 32 | Signed loop 3 stride |
| trig | input | 3 | Trigger lines (two global, one local) |
| rowValid | output | 1 | Row request valid |
| rowReady | input | 1 | Row request accepted |
| rowAddr | output | 64 | Row address |
| rowLen | output | 16 | Row byte count |
| eventPulse | output | 1 | Boundary event |
| respDone | output | 1 | Response valid strobe |
| respWord | output | 32 | Response word |

## Verification
The bench builds the block with its default widths: 64-bit addresses, 16-bit counts and 32-bit strides. These widths let negative strides carry an address below zero and wrap through the full 64-bit range, and they let the command id be checked in every response. Loop counts of two and three, combined with both stride signs, exercise every carry path between levels. Alternating back-pressure on rowReady keeps rows stalled while trigger pulses arrive, which reaches the pending-credit and lost-pulse cases.

// File: rtl/trw_pkg.sv
package trw_pkg;
  typedef struct packed {
    logic load;
    logic step;
  } dpCtl_t;

  localparam int NUM_OUTER = 3;
  localparam int NUM_TRIG_CH = 2;

  localparam logic [3:0] ST_OK = 4'd0;
  localparam logic [3:0] ST_SUBMIT_ERR = 4'd3;
  localparam logic [3:0] ST_UNSUPPORTED = 4'd4;
endpackage

// File: rtl/trw_datapath.sv
module trw_datapath
  import trw_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int CNT_W = 16,
  parameter int STRIDE_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  dpCtl_t                        ctl,
  input  logic [3:0]                    recType,
  input  logic [CNT_W-1:0]              cntInner,
  input  logic [NUM_OUTER*CNT_W-1:0]    cntOuter,
  input  logic [NUM_OUTER*STRIDE_W-1:0] strides,
  input  logic [ADDR_W-1:0]             baseAddr,
  output logic [ADDR_W-1:0]             curAddr,
  output logic [CNT_W-1:0]              curLen,
  output logic [NUM_OUTER-1:0]          lastFlag
);
  localparam int EXT_W = ADDR_W - STRIDE_W;

  logic [NUM_OUTER-1:0] carry;
  logic [ADDR_W-1:0] strideExt [NUM_OUTER];
  logic [ADDR_W-1:0] strideLat [NUM_OUTER];
  logic [ADDR_W-1:0] lvlAddr [NUM_OUTER];

  for (genvar k = 0; k < NUM_OUTER; k++) begin : g_lvl
    logic [CNT_W-1:0] idx, lim;
    logic [STRIDE_W-1:0] s;
    assign s = strides[k*STRIDE_W +: STRIDE_W];
    assign strideExt[k] = {{EXT_W{s[STRIDE_W-1]}}, s};
    assign lastFlag[k] = (idx == lim - 1'b1);
    if (k == 0) begin : g_c0
      assign carry[k] = 1'b1;
    end else begin : g_cn
      assign carry[k] = carry[k-1] & lastFlag[k-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        idx <= '0;
        lim <= CNT_W'(1);
        strideLat[k] <= '0;
      end else if (ctl.load) begin
        idx <= '0;
        strideLat[k] <= strideExt[k];
        if (recType > 4'(k) && cntOuter[k*CNT_W +: CNT_W] != '0)
          lim <= cntOuter[k*CNT_W +: CNT_W];
        else
          lim <= CNT_W'(1);
      end else if (ctl.step && carry[k]) begin
        idx <= lastFlag[k] ? '0 : idx + 1'b1;
      end
    end
  end

  // lvlAddr[0] is the current row; lvlAddr[k] marks where loop k last started.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_OUTER; k++) lvlAddr[k] <= '0;
      curLen <= '0;
    end else if (ctl.load) begin
      for (int k = 0; k < NUM_OUTER; k++) lvlAddr[k] <= baseAddr;
      curLen <= cntInner;
    end else if (ctl.step) begin
      if (!lastFlag[0]) begin
        lvlAddr[0] <= lvlAddr[0] + strideLat[0];
      end else if (!lastFlag[1]) begin
        lvlAddr[0] <= lvlAddr[1] + strideLat[1];
        lvlAddr[1] <= lvlAddr[1] + strideLat[1];
      end else begin
        for (int k = 0; k < NUM_OUTER; k++) lvlAddr[k] <= lvlAddr[2] + strideLat[2];
      end
    end
  end

  assign curAddr = lvlAddr[0];
endmodule

// File: rtl/trw_control.sv
module trw_control
  import trw_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [31:0]          flags,
  input  logic [CNT_W-1:0]     cnt0,
  input  logic [2:0]           trig,
  input  logic                 rowReady,
  input  logic [NUM_OUTER-1:0] lastFlag,
  output dpCtl_t               ctl,
  output logic                 rowValid,
  output logic                 eventPulse,
  output logic                 respDone,
  output logic [31:0]          respWord,
  output logic                 supActive
);
  logic running;
  logic [3:0] typeLat;
  logic [1:0] esLat;
  logic [7:0] cmdLat;
  logic [3:0] wrapUpTo;
  logic [NUM_TRIG_CH-1:0] gateOk;
  logic accept, load, badType, zeroLen, allLast, evHere;
  logic unusedFlagBits;

  assign unusedFlagBits = ^{flags[5:4], flags[25:24], flags[31:27]};
  assign load = start & ~running;
  assign badType = flags[3:0] > 4'd3;
  assign zeroLen = (cnt0 == '0);
  assign wrapUpTo = {&lastFlag, &lastFlag[1:0], lastFlag[0], 1'b1};
  assign allLast = wrapUpTo[3];
  assign rowValid = running & (&gateOk);
  assign accept = rowValid & rowReady;
  assign ctl.load = load & ~badType & ~zeroLen;
  assign ctl.step = accept & ~allLast;
  assign evHere = (esLat != 2'd0 && {2'b00, esLat} <= typeLat)
                  ? wrapUpTo[esLat - 2'd1] : allLast;

  for (genvar g = 0; g < NUM_TRIG_CH; g++) begin : g_ch
    logic [1:0] sel, tt;
    logic openQ, pendQ, hit, quotaEnd;
    always_comb begin
      case (sel)
        2'd1: hit = trig[0];
        2'd2: hit = trig[1];
        2'd3: hit = trig[2];
        default: hit = 1'b0;
      endcase
    end
    assign quotaEnd = accept & wrapUpTo[tt];
    assign gateOk[g] = (sel == 2'd0) | openQ;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel <= '0; tt <= '0; openQ <= 1'b0; pendQ <= 1'b0;
      end else if (ctl.load) begin
        sel <= flags[9 + 4*g -: 2];
        tt <= flags[11 + 4*g -: 2];
        openQ <= 1'b0;
        pendQ <= 1'b0;
      end else if (running) begin
        if (hit) begin
          if (openQ & ~quotaEnd) begin
            pendQ <= 1'b1;
          end else begin
            openQ <= 1'b1;
          end
        end else if (quotaEnd) begin
          openQ <= pendQ;
          pendQ <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0; typeLat <= '0; esLat <= '0; cmdLat <= '0;
      supActive <= 1'b0; eventPulse <= 1'b0; respDone <= 1'b0; respWord <= '0;
    end else begin
      respDone <= 1'b0;
      eventPulse <= 1'b0;
      if (load) begin
        typeLat <= flags[3:0];
        esLat <= flags[7:6];
        cmdLat <= flags[23:16];
        supActive <= flags[26];
        if (badType || zeroLen) begin
          respDone <= 1'b1;
          respWord <= {8'h00, flags[23:16], 8'h00, 4'h0,
                       badType ? ST_UNSUPPORTED : ST_SUBMIT_ERR};
        end else begin
          running <= 1'b1;
        end
      end else if (accept) begin
        eventPulse <= evHere & ~supActive;
        if (allLast) begin
          running <= 1'b0;
          respDone <= 1'b1;
          respWord <= {8'h00, cmdLat, 8'h00, 4'h0, ST_OK};
        end
      end
    end
  end
endmodule

// File: rtl/trw_addr_gen.sv
module trw_addr_gen
  import trw_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int CNT_W = 16,
  parameter int STRIDE_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [31:0]         flags,
  input  logic [CNT_W-1:0]    cnt0,
  input  logic [CNT_W-1:0]    cnt1,
  input  logic [CNT_W-1:0]    cnt2,
  input  logic [CNT_W-1:0]    cnt3,
  input  logic [ADDR_W-1:0]   baseAddr,
  input  logic [STRIDE_W-1:0] stride1,
  input  logic [STRIDE_W-1:0] stride2,
  input  logic [STRIDE_W-1:0] stride3,
  input  logic [2:0]          trig,
  output logic                rowValid,
  input  logic                rowReady,
  output logic [ADDR_W-1:0]   rowAddr,
  output logic [CNT_W-1:0]    rowLen,
  output logic                eventPulse,
  output logic                respDone,
  output logic [31:0]         respWord
);
  dpCtl_t ctl;
  logic [NUM_OUTER-1:0] lastFlag;
  logic supActive;

  trw_control #(.CNT_W(CNT_W)) i_ctl (
    .clk(clk), .rst_n(rst_n), .start(start), .flags(flags), .cnt0(cnt0),
    .trig(trig), .rowReady(rowReady), .lastFlag(lastFlag), .ctl(ctl),
    .rowValid(rowValid), .eventPulse(eventPulse), .respDone(respDone),
    .respWord(respWord), .supActive(supActive)
  );

  trw_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .STRIDE_W(STRIDE_W)) i_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .recType(flags[3:0]), .cntInner(cnt0),
    .cntOuter({cnt3, cnt2, cnt1}), .strides({stride3, stride2, stride1}),
    .baseAddr(baseAddr), .curAddr(rowAddr), .curLen(rowLen), .lastFlag(lastFlag)
  );
endmodule

// File: rtl/trw_checker.sv
module trw_checker #(
  parameter int ADDR_W = 64,
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rowValid,
  input logic              rowReady,
  input logic [ADDR_W-1:0] rowAddr,
  input logic [CNT_W-1:0]  rowLen,
  input logic              eventPulse,
  input logic              respDone,
  input logic [31:0]       respWord,
  input logic              supActive
);
  p_row_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rowValid && !rowReady |=> rowValid && $stable(rowAddr) && $stable(rowLen));

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    respDone |=> !respDone);

  p_resp_layout_r4: assert property (@(posedge clk) disable iff (!rst_n)
    respDone |-> respWord[15:4] == 12'h000 && respWord[31:24] == 8'h00);

  p_done_after_row_r4: assert property (@(posedge clk) disable iff (!rst_n)
    respDone && respWord[3:0] == 4'd0 |-> $past(rowValid && rowReady));

  p_len_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rowValid |-> rowLen != '0);

  p_no_event_sup_r11: assert property (@(posedge clk) disable iff (!rst_n)
    eventPulse |-> !supActive);
endmodule

bind trw_addr_gen trw_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .rowValid(rowValid), .rowReady(rowReady),
  .rowAddr(rowAddr), .rowLen(rowLen), .eventPulse(eventPulse),
  .respDone(respDone), .respWord(respWord), .supActive(supActive)
);

// File: tb/test_trw_addr_gen.sv
module test_trw_addr_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] flags = '0;
  logic [15:0] cnt0 = '0, cnt1 = '0, cnt2 = '0, cnt3 = '0;
  logic [63:0] baseAddr = '0;
  logic [31:0] stride1 = '0, stride2 = '0, stride3 = '0;
  logic [2:0] trig = '0;
  logic rowReady = 1'b1;
  logic rowValid, eventPulse, respDone;
  logic [63:0] rowAddr;
  logic [15:0] rowLen;
  logic [31:0] respWord;

  int nTests = 0, nFail = 0;
  int nRows = 0, nEvents = 0, nDone = 0;
  logic [63:0] gotAddr [64];
  logic [15:0] gotLen [64];
  logic [31:0] lastResp = '0;
  logic readyAlt = 1'b0;
  logic readyHold = 1'b1;

  trw_addr_gen i_trw_addr_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .flags(flags), .cnt0(cnt0),
    .cnt1(cnt1), .cnt2(cnt2), .cnt3(cnt3), .baseAddr(baseAddr),
    .stride1(stride1), .stride2(stride2), .stride3(stride3), .trig(trig),
    .rowValid(rowValid), .rowReady(rowReady), .rowAddr(rowAddr),
    .rowLen(rowLen), .eventPulse(eventPulse), .respDone(respDone),
    .respWord(respWord)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    #1;
    rowReady = readyAlt ? ~rowReady : readyHold;
  end

  always @(negedge clk) begin
    if (rowValid && rowReady) begin
      if (nRows < 64) begin
        gotAddr[nRows] = rowAddr;
        gotLen[nRows] = rowLen;
      end
      nRows++;
    end
    if (eventPulse) nEvents++;
    if (respDone) begin
      nDone++;
      lastResp = respWord;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkFlags(input int ty, input int es, input int s0, input int t0,
                                          input int s1, input int t1, input int cmd, input bit sup);
    return 32'(ty) | (32'(es) << 6) | (32'(s0) << 8) | (32'(t0) << 10) |
           (32'(s1) << 12) | (32'(t1) << 14) | (32'(cmd) << 16) | (32'(sup) << 26);
  endfunction

  task automatic clearMon();
    nRows = 0; nEvents = 0; nDone = 0;
  endtask

  task automatic submit(input logic [31:0] f, input logic [15:0] c0, input logic [15:0] c1,
                        input logic [15:0] c2, input logic [15:0] c3, input logic [63:0] b,
                        input logic [31:0] s1, input logic [31:0] s2, input logic [31:0] s3);
    @(posedge clk); #2;
    flags = f; cnt0 = c0; cnt1 = c1; cnt2 = c2; cnt3 = c3;
    baseAddr = b; stride1 = s1; stride2 = s2; stride3 = s3; start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
  endtask

  task automatic waitDone(input int maxCyc);
    for (int i = 0; i < maxCyc && nDone == 0; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulse(input int line);
    @(posedge clk); #2;
    trig[line] = 1'b1;
    @(posedge clk); #2;
    trig[line] = 1'b0;
  endtask

  task automatic checkWalk(input string req, input int e1, input int e2, input int e3,
                           input logic [63:0] b, input logic [31:0] s1,
                           input logic [31:0] s2, input logic [31:0] s3, input logic [15:0] len);
    int n = 0;
    chk(nRows == e1 * e2 * e3, req, nRows, e1 * e2 * e3);
    for (int k = 0; k < e3; k++)
      for (int j = 0; j < e2; j++)
        for (int i = 0; i < e1; i++) begin
          logic [63:0] exp;
          exp = b + 64'(longint'(i) * longint'(signed'(s1)))
                  + 64'(longint'(j) * longint'(signed'(s2)))
                  + 64'(longint'(k) * longint'(signed'(s3)));
          if (n < nRows && n < 64) begin
            chk(gotAddr[n] == exp, req, gotAddr[n], exp);
            chk(gotLen[n] == len, req, gotLen[n], len);
          end
          n++;
        end
  endtask

  task automatic t_reset();
    chk(rowValid == 1'b0, "R3 reset rowValid", rowValid, 0);
    chk(respDone == 1'b0, "R4 reset respDone", respDone, 0);
    chk(eventPulse == 1'b0, "R10 reset eventPulse", eventPulse, 0);
  endtask

  task automatic t_type0();
    clearMon();
    submit(mkFlags(0, 0, 0, 0, 0, 0, 8'h5A, 0), 16'd64, 16'd9, 16'd9, 16'd9,
           64'h1000, 32'h10, 32'h20, 32'h30);
    waitDone(50);
    checkWalk("R2 type0 single row", 1, 1, 1, 64'h1000, 32'h10, 32'h20, 32'h30, 16'd64);
    chk(lastResp == 32'h005A_0000, "R4 complete response", lastResp, 32'h005A_0000);
    chk(nEvents == 1, "R10 code0 event at completion", nEvents, 1);
  endtask

  task automatic t_type2();
    clearMon();
    readyAlt = 1'b1;
    submit(mkFlags(2, 2, 0, 0, 0, 0, 8'h11, 0), 16'd32, 16'd3, 16'd2, 16'd7,
           64'h1000_0000_0000, 32'h100, 32'hFFFF_FFC0, 32'h4);
    waitDone(100);
    readyAlt = 1'b0;
    checkWalk("R1 type2 walk", 3, 2, 1, 64'h1000_0000_0000, 32'h100, 32'hFFFF_FFC0, 32'h4, 16'd32);
    chk(nEvents == 2, "R10 code2 per i1 loop", nEvents, 2);
    chk(lastResp == 32'h0011_0000, "R4 response cmd", lastResp, 32'h0011_0000);
  endtask

  task automatic t_type3();
    clearMon();
    submit(mkFlags(3, 3, 0, 0, 0, 0, 8'h22, 0), 16'd8, 16'd2, 16'd2, 16'd2,
           64'h2000, 32'hFFFF_FFF8, 32'h1000, 32'hFFFE_0000);
    waitDone(100);
    checkWalk("R1 type3 negative wrap", 2, 2, 2, 64'h2000, 32'hFFFF_FFF8, 32'h1000, 32'hFFFE_0000, 16'd8);
    chk(nEvents == 2, "R10 code3 per i2 block", nEvents, 2);
  endtask

  task automatic t_esAboveType();
    clearMon();
    submit(mkFlags(1, 3, 0, 0, 0, 0, 1, 0), 16'd4, 16'd0, 16'd5, 16'd5,
           64'h40, 32'h8, 32'h0, 32'h0);
    waitDone(50);
    checkWalk("R2 zero outer count as one", 1, 1, 1, 64'h40, 32'h8, 32'h0, 32'h0, 16'd4);
    chk(nEvents == 1, "R10 code above type fires at end", nEvents, 1);
    clearMon();
    submit(mkFlags(1, 1, 0, 0, 0, 0, 1, 0), 16'd4, 16'd3, 16'd0, 16'd0,
           64'h40, 32'h8, 32'h0, 32'h0);
    waitDone(50);
    chk(nEvents == 3, "R10 code1 every row", nEvents, 3);
  endtask

  task automatic t_suppress();
    clearMon();
    submit(mkFlags(1, 1, 0, 0, 0, 0, 3, 1), 16'd4, 16'd4, 16'd0, 16'd0,
           64'h0, 32'h4, 32'h0, 32'h0);
    waitDone(50);
    chk(nEvents == 0, "R11 suppressed events", nEvents, 0);
    chk(nRows == 4, "R11 rows still issued", nRows, 4);
  endtask

  task automatic t_errors();
    clearMon();
    submit(mkFlags(1, 0, 0, 0, 0, 0, 8'h33, 0), 16'd0, 16'd2, 16'd0, 16'd0,
           64'h0, 32'h4, 32'h0, 32'h0);
    waitDone(10);
    chk(lastResp == 32'h0033_0003, "R5 zero count status", lastResp, 32'h0033_0003);
    chk(nRows == 0, "R5 no rows", nRows, 0);
    clearMon();
    submit(mkFlags(9, 0, 0, 0, 0, 0, 8'h44, 0), 16'd8, 16'd2, 16'd0, 16'd0,
           64'h0, 32'h4, 32'h0, 32'h0);
    waitDone(10);
    chk(lastResp == 32'h0044_0004, "R6 unsupported status", lastResp, 32'h0044_0004);
    chk(nRows == 0, "R6 no rows", nRows, 0);
    clearMon();
    submit(mkFlags(4, 0, 0, 0, 0, 0, 8'h45, 0), 16'd0, 16'd2, 16'd0, 16'd0,
           64'h0, 32'h4, 32'h0, 32'h0);
    waitDone(10);
    chk(lastResp == 32'h0045_0004, "R6 priority over zero count", lastResp, 32'h0045_0004);
  endtask

  task automatic t_trigRow();
    clearMon();
    pulse(0);
    submit(mkFlags(1, 0, 1, 0, 0, 0, 5, 0), 16'd4, 16'd3, 16'd0, 16'd0,
           64'h0, 32'h10, 32'h0, 32'h0);
    repeat (5) @(negedge clk);
    chk(nRows == 0, "R12 idle pulse ignored and R7 gate closed", nRows, 0);
    pulse(1);
    repeat (4) @(negedge clk);
    chk(nRows == 0, "R7 wrong line ignored", nRows, 0);
    pulse(0);
    repeat (4) @(negedge clk);
    chk(nRows == 1, "R8 type0 one row per pulse", nRows, 1);
    pulse(0); repeat (3) @(negedge clk);
    pulse(0);
    waitDone(20);
    chk(nRows == 3 && nDone == 1, "R8 finished after three pulses", nRows, 3);
  endtask

  task automatic t_pending();
    clearMon();
    submit(mkFlags(1, 0, 2, 0, 0, 0, 6, 0), 16'd4, 16'd5, 16'd0, 16'd0,
           64'h0, 32'h10, 32'h0, 32'h0);
    @(posedge clk); #2; readyHold = 1'b0;
    pulse(1); pulse(1); pulse(1);
    @(posedge clk); #2; readyHold = 1'b1;
    repeat (8) @(negedge clk);
    chk(nRows == 2, "R9 one credit kept, extra lost", nRows, 2);
    for (int i = 0; i < 3; i++) begin
      pulse(1);
      repeat (3) @(negedge clk);
    end
    waitDone(20);
    chk(nRows == 5 && nDone == 1, "R9 rest released", nRows, 5);
  endtask

  task automatic t_trigLoop();
    clearMon();
    submit(mkFlags(2, 0, 3, 1, 0, 0, 7, 0), 16'd4, 16'd2, 16'd2, 16'd0,
           64'h0, 32'h10, 32'h100, 32'h0);
    pulse(2);
    repeat (6) @(negedge clk);
    chk(nRows == 2, "R8 type1 releases one i1 loop", nRows, 2);
    pulse(2);
    waitDone(20);
    chk(nRows == 4 && nDone == 1, "R8 second loop", nRows, 4);
  endtask

  task automatic t_twoCh();
    clearMon();
    submit(mkFlags(1, 0, 1, 3, 3, 3, 8'h77, 0), 16'd4, 16'd3, 16'd0, 16'd0,
           64'h0, 32'h10, 32'h0, 32'h0);
    pulse(0);
    repeat (5) @(negedge clk);
    chk(nRows == 0, "R7 both channels required", nRows, 0);
    @(posedge clk); #2;
    start = 1'b1; flags = mkFlags(0, 0, 0, 0, 0, 0, 8'h99, 0);
    @(posedge clk); #2;
    start = 1'b0;
    pulse(2);
    waitDone(30);
    chk(nRows == 3, "R8 type3 releases rest", nRows, 3);
    chk(lastResp[23:16] == 8'h77, "R12 start while running ignored", lastResp[23:16], 8'h77);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(posedge clk); #2; rst_n = 1'b1;
    t_type0();
    t_type2();
    t_type3();
    t_esAboveType();
    t_suppress();
    t_errors();
    t_trigRow();
    t_pending();
    t_trigLoop();
    t_twoCh();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #200000;
    nTests++;
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule